// File: doc/BRIEF.md
# Serial Receiver with Interrupt-Flag Interlock

This block is the receive half of an asynchronous serial port. A bit-sample strobe runs at a fixed multiple of the bit rate. The receiver uses it to find a start bit and confirm it at mid-bit. It then samples each following bit at its centre and shifts it into an input register, least significant bit first. The last bit sampled is the ninth after the start bit. At that point the eight data bits go to a receive buffer, the ninth bit goes to an extra-bit register, and a receive flag is raised for software. That ninth bit is either the stop bit, in eight-bit framing, or the ninth data bit, in nine-bit framing.

Software acknowledges a frame by pulsing a clear strobe. While the flag remains set, completed frames do not reach the outputs. The buffer keeps the old byte, the extra bit keeps its value, and no new flag event occurs. The input shift register keeps receiving all the same, so each frame that completes during this time is lost. The receiver reports each such loss with a one-cycle overrun pulse.

Top module: `uart_rx_interlock`

## Requirements
- R1: With `samp_stb` high, a low `rxd` in idle starts a frame. The line is sampled again `OVS/2` strobes later. If it is high at that point, the start is rejected as false and nothing is received.
- R2: Data bits are sampled every `OVS` strobes after the confirmed start centre. They are taken least significant bit first, and the eight data bits appear on `rx_buf` (bit 0 = first bit after start).
- R3: The ninth bit sampled after the start bit is stored in `rx_bit8`.
- R4: `ri_flag` rises on the clock edge that follows the strobe which samples the ninth bit, provided the flag was clear at that strobe.
- R5: While `ri_flag` is high, neither `rx_buf` nor `rx_bit8` changes.
- R6: While `ri_flag` is high, a completing frame raises no new flag event: the flag stays high until it is cleared.
- R7: A frame that completes while `ri_flag` is high produces exactly one cycle of `overrun`.
- R8: `ri_clr` clears `ri_flag` at the next clock edge. When a clear and a frame completion fall in the same cycle, the flag ends up set.
- R9: The shift register keeps receiving while the flag is set. After a clear, the next complete frame is delivered intact.
- R10: After reset, `rx_buf`, `rx_bit8`, `ri_flag` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_stb | input | 1 | Bit-sample strobe, OVS per bit time |
| rxd | input | 1 | Serial data line, idle high |
| ri_clr | input | 1 | Software clear of the receive flag |
| rx_buf | output | 8 | Receive buffer |
| rx_bit8 | output | 1 | Extra (ninth) received bit |
| ri_flag | output | 1 | Receive flag |
| overrun | output | 1 | One-cycle pulse when a frame is lost |

## Verification
The bound checker verifies the interlock on every cycle. Buffer and extra bit must hold while the flag is high, and the flag must stay high unless cleared. A clear of a set flag must take effect at the next edge. The overrun pulse must last one cycle and follow a set flag. Only the bench scenarios can show the rest: that serial bits land LSB first in the right positions, that a glitch shorter than half a bit is rejected, that set wins over a simultaneous clear, and that the frame after a lost one arrives intact.

// File: rtl/uart_rx_interlock.sv
module uart_rx_interlock #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_stb,
  input  logic          rxd,
  input  logic          ri_clr,
  output logic [DW-1:0] rx_buf,
  output logic          rx_bit8,
  output logic          ri_flag,
  output logic          overrun
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_WAITHI} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW:0]   sh;

  wire          at_mid  = cnt == CW'(OVS/2 - 1);
  wire          at_full = cnt == CW'(OVS - 1);
  wire          at_last = bitn == BW'(DW);
  wire [DW:0]   sh_nx   = {rxd, sh[DW:1]};
  wire          done    = samp_stb && (st == S_DATA) && at_full && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else if (samp_stb) begin
      case (st)
        S_IDLE: if (!rxd) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: begin
          cnt <= cnt + 1'b1;
          if (at_mid) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxd ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          cnt <= at_full ? '0 : cnt + 1'b1;
          if (at_full) begin
            sh   <= sh_nx;
            bitn <= bitn + 1'b1;
            if (at_last) st <= S_WAITHI;
          end
        end
        default: if (rxd) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_bit8 <= 1'b0;
      ri_flag <= 1'b0;
      overrun <= 1'b0;
    end else begin
      overrun <= done && ri_flag;
      if (done && !ri_flag) begin
        rx_buf  <= sh_nx[DW-1:0];
        rx_bit8 <= sh_nx[DW];
        ri_flag <= 1'b1;
      end else if (ri_clr) begin
        ri_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_interlock_chk.sv
module uart_rx_interlock_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ri_clr,
  input logic [DW-1:0] rx_buf,
  input logic          rx_bit8,
  input logic          ri_flag,
  input logic          overrun
);
  p_hold_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ri_flag |=> $stable(rx_buf));
  p_hold_bit8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ri_flag |=> $stable(rx_bit8));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_flag && !ri_clr) |=> ri_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_flag && ri_clr) |=> !ri_flag);
  p_ovr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
  p_ovr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(ri_flag));
endmodule

bind uart_rx_interlock uart_rx_interlock_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ri_clr(ri_clr), .rx_buf(rx_buf),
  .rx_bit8(rx_bit8), .ri_flag(ri_flag), .overrun(overrun)
);

// File: tb/sim_uart_rx_interlock.sv
module sim_uart_rx_interlock;
  localparam int OVS = 16;
  logic clk = 1'b0, rst_n = 1'b0, samp_stb = 1'b0, rxd = 1'b1, ri_clr = 1'b0;
  logic [7:0] rx_buf;
  logic rx_bit8, ri_flag, overrun;
  int errors = 0, checks = 0, ovr_cycles = 0, ri_rises = 0;
  logic ri_q = 1'b0;

  uart_rx_interlock #(.OVS(OVS), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .rxd(rxd), .ri_clr(ri_clr),
    .rx_buf(rx_buf), .rx_bit8(rx_bit8), .ri_flag(ri_flag), .overrun(overrun));

  always #5 clk = ~clk;
  always @(negedge clk) samp_stb <= ~samp_stb;
  always @(negedge clk) begin
    if (rst_n && overrun) ovr_cycles++;
    if (rst_n && ri_flag && !ri_q) ri_rises++;
    ri_q <= ri_flag;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(logic b);
    rxd = b;
    repeat (2*OVS) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic b8);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    hold_bit(b8);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic clear_flag();
    @(negedge clk) ri_clr = 1'b1;
    @(negedge clk) ri_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 buf", rx_buf, 0);
    chk("R10 bit8", rx_bit8, 0);
    chk("R10 flag", ri_flag, 0);
    chk("R10 ovr", overrun, 0);
  endtask

  task automatic t_first_frame();
    send_frame(8'hA5, 1'b1);
    chk("R2 buf", rx_buf, 8'hA5);
    chk("R3 bit8", rx_bit8, 1);
    chk("R4 flag", ri_flag, 1);
    chk("R4 rises", ri_rises, 1);
  endtask

  task automatic t_overrun();
    send_frame(8'h3C, 1'b0);
    chk("R5 buf held", rx_buf, 8'hA5);
    chk("R5 bit8 held", rx_bit8, 1);
    chk("R6 no new rise", ri_rises, 1);
    chk("R6 flag", ri_flag, 1);
    chk("R7 overrun cycles", ovr_cycles, 1);
  endtask

  task automatic t_clear_then_frame();
    clear_flag();
    chk("R8 cleared", ri_flag, 0);
    send_frame(8'h5A, 1'b0);
    chk("R9 buf", rx_buf, 8'h5A);
    chk("R9 bit8", rx_bit8, 0);
    chk("R9 rises", ri_rises, 2);
    chk("R7 no extra overrun", ovr_cycles, 1);
    clear_flag();
  endtask

  task automatic t_false_start();
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (4*OVS) @(negedge clk);
    chk("R1 no flag", ri_flag, 0);
    chk("R1 buf kept", rx_buf, 8'h5A);
    send_frame(8'h81, 1'b1);
    chk("R1 next frame", rx_buf, 8'h81);
    chk("R2 msb/lsb", rx_bit8, 1);
    clear_flag();
  endtask

  task automatic t_set_wins();
    ri_clr = 1'b1;
    send_frame(8'h0F, 1'b1);
    ri_clr = 1'b0;
    chk("R8 set won", ri_rises, 4);
    chk("R8 buf", rx_buf, 8'h0F);
    chk("R8 flag cleared after", ri_flag, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_overrun();
    t_clear_then_frame();
    t_false_start();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule